// File: doc/BRIEF.md
# Word/Byte Arithmetic-Logic Unit with Status Flags

The block is a combinational arithmetic-logic unit over two operands of 16 bits, with a small registered status word beside it. An operation code picks one of ten functions: add, subtract, AND, OR, XOR, increment, decrement, one's complement, shift left by one and shift right by one. A width input picks between word operation over all 16 bits and byte operation over the low 8 bits only. The result appears on the output in the same cycle as the operands.

Five status bits are kept: carry, nibble carry, parity, zero and sign. They are worked out from the current result every cycle, but they are written into the status register only on a clock edge where the valid strobe is high. Increment and decrement leave the stored carry alone, so a multi-word count can run through them without losing the carry from an earlier add. The status register resets to all zeros.

Top module: `alu16_core`

## Requirements
- R1: op_i selects the function: 0 add (a+b), 1 subtract (a-b), 2 AND, 3 OR, 4 XOR, 5 increment (a+1), 6 decrement (a-1), 7 complement (~a), 8 shift left by one, 9 shift right by one (zero filled). b_i is used only by codes 0 to 4. res_o follows the inputs in the same cycle.
- R2: With byte_i=1 the operation uses only bits 7:0 of the operands, res_o[15:8] is 0, and carry, zero and sign refer to the low byte (carry out of bit 7, sign is bit 7). With byte_i=0 they refer to all 16 bits (carry out of bit 15, sign is bit 15).
- R3: After add, carry (flags_o[0]) is the unsigned carry out of the top bit of the chosen width. After subtract, it is 1 exactly when a borrow is needed (a < b unsigned, over the chosen width).
- R4: flags_o[1] (nibble carry) is 1 after add or increment when there is a carry from bit 3 into bit 4, and after subtract or decrement when there is a borrow from bit 4 into bit 3. It is 0 after every other operation.
- R5: flags_o[2] (parity) is 1 when res_o[7:0] holds an even number of ones and 0 when odd, in both widths.
- R6: flags_o[3] (zero) is 1 exactly when the result over the chosen width is all zeros. flags_o[4] (sign) is the top bit of the result over the chosen width.
- R7: AND, OR, XOR and complement clear both carry and nibble carry.
- R8: Increment and decrement leave the carry flag at its stored value.
- R9: Shift left puts the bit shifted out of the top of the chosen width into carry. Shift right puts bit 0 of the operand into carry.
- R10: flags_o changes only on a rising clock edge where valid_i is 1. With valid_i=0 it keeps its value whatever the other inputs do.
- R11: While rst_ni is low, flags_o is 0.
- R12: Op codes 10 to 15 give a result of 0. When they are strobed, the flags are carry 0, nibble carry 0, zero 1, parity 1, sign 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Strobe: write the new flags at this edge |
| op_i | input | 4 | Operation code |
| byte_i | input | 1 | 1 = byte width, 0 = word width |
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| res_o | output | 16 | Combinational result |
| flags_o | output | 5 | Status: bit 4 sign, 3 zero, 2 parity, 1 nibble carry, 0 carry |

## Verification
On every cycle the assertions check that flags hold when the strobe is low, that parity and zero match the strobed result, that the upper byte is clear in byte width, that logical functions clear both carries and that increment and decrement keep the carry. The exact carry and nibble-carry values of add, subtract and the shifts, the width-dependent sign, and the effect of unused codes depend on operand values. Only the bench's scenarios show these, with a reference model scoring each result and status word.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_AND = 4'd2,
    OP_OR  = 4'd3,
    OP_XOR = 4'd4,
    OP_INC = 4'd5,
    OP_DEC = 4'd6,
    OP_NOT = 4'd7,
    OP_SHL = 4'd8,
    OP_SHR = 4'd9
  } alu_op_e;

  // bit 4 .. bit 0
  typedef struct packed {
    logic sf;
    logic zf;
    logic pf;
    logic af;
    logic cf;
  } alu_flags_t;

endpackage

// File: rtl/alu16_arith.sv
module alu16_arith
  import alu16_pkg::*;
#(
  parameter int DW = 16
) (
  input  alu_op_e         op_i,
  input  logic            byte_i,
  input  logic [DW-1:0]   a_i,
  input  logic [DW-1:0]   b_i,
  output logic [DW-1:0]   res_o,
  output logic            cy_o,
  output logic            ac_o
);
  localparam int HW = DW / 2;

  logic [DW-1:0] b_eff;
  logic          cin;
  logic          inv;   // borrow sense for subtract/decrement
  logic [DW:0]   sum_w;
  logic [HW:0]   sum_b;
  logic [DW-1:0] nib;

  always_comb begin
    b_eff = b_i;
    cin   = 1'b0;
    inv   = 1'b0;
    unique case (op_i)
      OP_SUB: begin b_eff = ~b_i;        cin = 1'b1; inv = 1'b1; end
      OP_INC: begin b_eff = '0;          cin = 1'b1; end
      OP_DEC: begin b_eff = '1;          inv = 1'b1; end
      default: ;
    endcase
  end

  assign sum_w = {1'b0, a_i} + {1'b0, b_eff} + {{DW{1'b0}}, cin};
  assign sum_b = {1'b0, a_i[HW-1:0]} + {1'b0, b_eff[HW-1:0]} + {{HW{1'b0}}, cin};
  assign nib   = a_i ^ b_eff ^ sum_w[DW-1:0];

  assign res_o = byte_i ? {{(DW-HW){1'b0}}, sum_b[HW-1:0]} : sum_w[DW-1:0];
  assign cy_o  = (byte_i ? sum_b[HW] : sum_w[DW]) ^ inv;
  assign ac_o  = nib[4] ^ inv;

endmodule

// File: rtl/alu16_logic.sv
module alu16_logic
  import alu16_pkg::*;
#(
  parameter int DW = 16
) (
  input  alu_op_e         op_i,
  input  logic            byte_i,
  input  logic [DW-1:0]   a_i,
  input  logic [DW-1:0]   b_i,
  output logic [DW-1:0]   res_o,
  output logic            cy_o
);
  localparam int HW = DW / 2;

  logic [DW-1:0] mask;
  logic [DW-1:0] a_m;
  logic [DW-1:0] b_m;

  assign mask = byte_i ? {{(DW-HW){1'b0}}, {HW{1'b1}}} : {DW{1'b1}};
  assign a_m  = a_i & mask;
  assign b_m  = b_i & mask;

  always_comb begin
    res_o = '0;
    cy_o  = 1'b0;
    unique case (op_i)
      OP_AND: res_o = a_m & b_m;
      OP_OR:  res_o = a_m | b_m;
      OP_XOR: res_o = a_m ^ b_m;
      OP_NOT: res_o = ~a_m & mask;
      OP_SHL: begin
        res_o = (a_m << 1) & mask;
        cy_o  = byte_i ? a_i[HW-1] : a_i[DW-1];
      end
      OP_SHR: begin
        res_o = a_m >> 1;
        cy_o  = a_m[0];
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/alu16_flags.sv
module alu16_flags
  import alu16_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          byte_i,
  input  logic [DW-1:0] res_i,
  input  logic          cy_i,
  input  logic          ac_i,
  input  logic          keep_cy_i,
  output alu_flags_t    flags_o
);
  localparam int HW = DW / 2;

  alu_flags_t flags_q;
  alu_flags_t flags_d;

  always_comb begin
    flags_d.cf = keep_cy_i ? flags_q.cf : cy_i;
    flags_d.af = ac_i;
    flags_d.pf = ~^res_i[7:0];
    flags_d.zf = byte_i ? (res_i[HW-1:0] == '0) : (res_i == '0);
    flags_d.sf = byte_i ? res_i[HW-1] : res_i[DW-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      flags_q <= '0;
    else if (valid_i) flags_q <= flags_d;
  end

  assign flags_o = flags_q;

  AST_FLAGS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(flags_q)); // R10
  AST_PARITY_LOW_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (flags_q.pf == ~^$past(res_i[7:0]))); // R5
  AST_ZERO_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (flags_q.zf == ($past(res_i) == '0))); // R6

endmodule

// File: rtl/alu16_core.sv
module alu16_core
  import alu16_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [3:0]    op_i,
  input  logic          byte_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [DW-1:0] res_o,
  output logic [4:0]    flags_o
);
  localparam int HW = DW / 2;

  alu_op_e       op;
  logic          is_arith;
  logic          is_incdec;
  logic [DW-1:0] arith_res;
  logic          arith_cy;
  logic          arith_ac;
  logic [DW-1:0] logic_res;
  logic          logic_cy;
  alu_flags_t    flags_q;

  assign op        = alu_op_e'(op_i);
  assign is_incdec = (op == OP_INC) || (op == OP_DEC);
  assign is_arith  = (op == OP_ADD) || (op == OP_SUB) || is_incdec;

  alu16_arith #(.DW(DW)) arith_i (
    .op_i   (op),
    .byte_i (byte_i),
    .a_i    (a_i),
    .b_i    (b_i),
    .res_o  (arith_res),
    .cy_o   (arith_cy),
    .ac_o   (arith_ac)
  );

  alu16_logic #(.DW(DW)) logic_i (
    .op_i   (op),
    .byte_i (byte_i),
    .a_i    (a_i),
    .b_i    (b_i),
    .res_o  (logic_res),
    .cy_o   (logic_cy)
  );

  assign res_o = is_arith ? arith_res : logic_res;

  alu16_flags #(.DW(DW)) flags_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (valid_i),
    .byte_i    (byte_i),
    .res_i     (res_o),
    .cy_i      (is_arith ? arith_cy : logic_cy),
    .ac_i      (is_arith & arith_ac),
    .keep_cy_i (is_incdec),
    .flags_o   (flags_q)
  );

  assign flags_o = flags_q;

  AST_BYTE_UPPER_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_i |-> (res_o[DW-1:HW] == '0)); // R2
  AST_LOGIC_CLEARS_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (op_i inside {4'd2, 4'd3, 4'd4, 4'd7})) |=> (!flags_o[0] && !flags_o[1])); // R7
  AST_INCDEC_KEEPS_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (op_i inside {4'd5, 4'd6})) |=> (flags_o[0] == $past(flags_o[0]))); // R8

endmodule

// File: tb/alu16_core_tb.sv
`timescale 1ns/1ps
module alu16_core_tb_top;

  typedef struct {
    logic [15:0] res;
    logic [4:0]  flags;
    string       tag;
  } exp_t;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [3:0]  op_i = '0;
  logic        byte_i = 1'b0;
  logic [15:0] a_i = '0;
  logic [15:0] b_i = '0;
  logic [15:0] res_o;
  logic [4:0]  flags_o;

  int   total = 0;
  int   bad = 0;
  exp_t sb_q[$];
  logic [4:0] model_flags = '0;

  always #2.5 clk_i = ~clk_i;

  alu16_core dut_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .op_i    (op_i),
    .byte_i  (byte_i),
    .a_i     (a_i),
    .b_i     (b_i),
    .res_o   (res_o),
    .flags_o (flags_o)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference model: returns {flags, result}
  function automatic logic [20:0] model(input logic [3:0] op, input logic byt,
                                        input logic [15:0] a, input logic [15:0] b,
                                        input logic prev_cf);
    int unsigned w    = byt ? 8 : 16;
    int unsigned mask = byt ? 32'hFF : 32'hFFFF;
    int unsigned am   = a & mask;
    int unsigned bm   = b & mask;
    int unsigned r    = 0;
    logic cf = 1'b0, af = 1'b0, pf, zf, sf;
    case (op)
      4'd0: begin r = (am + bm) & mask; cf = ((am + bm) >> w) & 1; af = ((am & 15) + (bm & 15)) > 15; end
      4'd1: begin r = (am - bm) & mask; cf = am < bm; af = (am & 15) < (bm & 15); end
      4'd2: r = am & bm;
      4'd3: r = am | bm;
      4'd4: r = am ^ bm;
      4'd5: begin r = (am + 1) & mask; cf = prev_cf; af = (am & 15) == 15; end
      4'd6: begin r = (am - 1) & mask; cf = prev_cf; af = (am & 15) == 0; end
      4'd7: r = ~am & mask;
      4'd8: begin r = (am << 1) & mask; cf = (am >> (w - 1)) & 1; end
      4'd9: begin r = am >> 1; cf = am & 1; end
      default: r = 0;
    endcase
    pf = ~^r[7:0];
    zf = (r == 0);
    sf = (r >> (w - 1)) & 1;
    return {sf, zf, pf, af, cf, r[15:0]};
  endfunction

  task automatic drive(input logic [3:0] op, input logic byt, input logic [15:0] a,
                       input logic [15:0] b, input logic vld, input string tag);
    logic [20:0] m;
    exp_t e;
    @(negedge clk_i);
    op_i = op; byte_i = byt; a_i = a; b_i = b; valid_i = vld;
    m = model(op, byt, a, b, model_flags[0]);
    if (vld) model_flags = m[20:16];
    e.res = m[15:0];
    e.flags = model_flags;
    e.tag = tag;
    sb_q.push_back(e);
  endtask

  // Monitor: result and newly latched flags, just after the edge
  always @(posedge clk_i) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      #1;
      e = sb_q.pop_front();
      check({e.tag, " result"}, res_o, e.res);
      check({e.tag, " flags"}, {11'd0, flags_o}, {11'd0, e.flags});
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 check("R11 flags in reset", {11'd0, flags_o}, 16'd0);
    @(negedge clk_i) rst_ni = 1'b1;

    drive(4'd0, 1'b0, 16'h1234, 16'h4321, 1'b1, "R1 add");
    drive(4'd0, 1'b0, 16'hFFFF, 16'h0001, 1'b1, "R3 add carry zero");
    drive(4'd2, 1'b0, 16'hF0F0, 16'h0FF0, 1'b1, "R7 and clears carry");
    drive(4'd0, 1'b0, 16'h000F, 16'h0001, 1'b1, "R4 add nibble carry");
    drive(4'd1, 1'b0, 16'h0005, 16'h0006, 1'b1, "R3 sub borrow sign");
    drive(4'd1, 1'b0, 16'h0010, 16'h0001, 1'b1, "R4 sub nibble borrow");
    drive(4'd5, 1'b0, 16'h000F, 16'h0000, 1'b1, "R8 inc keeps carry");
    drive(4'd3, 1'b0, 16'h0100, 16'h0000, 1'b1, "R5 parity low byte zero");
    drive(4'd6, 1'b0, 16'h0000, 16'h0000, 1'b1, "R8 dec keeps clear carry");
    drive(4'd0, 1'b0, 16'h0300, 16'h0001, 1'b1, "R5 parity odd");
    drive(4'd0, 1'b1, 16'h12F0, 16'h3410, 1'b1, "R2 byte add carry");
    drive(4'd1, 1'b1, 16'hAA80, 16'h5501, 1'b1, "R2 byte sub");
    drive(4'd0, 1'b1, 16'h0040, 16'h0040, 1'b1, "R6 byte sign");
    drive(4'd4, 1'b0, 16'hFF00, 16'h0FF0, 1'b1, "R7 xor");
    drive(4'd0, 1'b0, 16'h8000, 16'h8000, 1'b1, "R3 add top carry");
    drive(4'd7, 1'b0, 16'h00FF, 16'h1234, 1'b1, "R7 complement word");
    drive(4'd7, 1'b1, 16'hFF0F, 16'h0000, 1'b1, "R2 complement byte");
    drive(4'd8, 1'b0, 16'h8001, 16'h0000, 1'b1, "R9 shl word");
    drive(4'd8, 1'b1, 16'h7F81, 16'h0000, 1'b1, "R9 shl byte");
    drive(4'd9, 1'b0, 16'h0003, 16'h0000, 1'b1, "R9 shr");
    drive(4'd2, 1'b0, 16'h0000, 16'h0000, 1'b1, "R7 and zero");
    drive(4'd0, 1'b0, 16'hFFFF, 16'h0001, 1'b0, "R10 no strobe");
    drive(4'd8, 1'b0, 16'hFFFF, 16'h0000, 1'b0, "R10 no strobe shl");
    drive(4'd12, 1'b0, 16'hFFFF, 16'hFFFF, 1'b1, "R12 unused code");
    drive(4'd15, 1'b1, 16'h1234, 16'h5678, 1'b1, "R12 unused code byte");
    for (int i = 0; i < 60; i++) begin
      drive(4'($urandom_range(0, 9)), 1'($urandom_range(0, 1)), 16'($urandom),
            16'($urandom), 1'($urandom_range(0, 1)), "R1 random");
    end
    @(negedge clk_i) valid_i = 1'b0;
    repeat (4) @(posedge clk_i);
    #2;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule